// File: doc/BRIEF.md
# Multichannel DMA Event Scheduler

This block keeps the control word of six DMA channels and decides, every cycle, which channel the transfer engine should serve next. Software programs each channel through a small register bus with a single write strobe and a channel index. A read port returns the control word of the addressed channel. Each channel names one of sixteen external synchronization sources through a 5-bit event code. A rising edge on the chosen source is held as a pending request until the engine takes a grant for that channel.

Ready channels compete in two groups. The priority bit of each control word places the channel in a group, and the high group always beats the low group. Inside a group the grant rotates. The engine sees a combinational grant valid and channel index, and it accepts the grant with a ready strobe. When the engine reports that a block has finished on a channel, the block raises that channel's interrupt for one cycle. A shared mux-mode input decides whether four of the event codes reach the third serial port or the UART.

Top module: `dma_evsched`

## Requirements
- R1: The control words reset to zero. A write with `reg_wr` high stores `reg_wdata` into channel `reg_addr` at the next clock edge. `reg_rdata` shows the control word of channel `reg_addr` combinationally. An index of 6 or 7 is ignored on write and reads as zero. Field positions: bit 7 enable, bit 6 high priority, bits 4:0 event code. Bits 15:8 and bit 5 are stored and read back only.
- R2: An enabled channel with event code 0 is ready in every cycle. A disabled channel is never granted.
- R3: Source index of `ev_in`: 0/1 serial port 0 receive/transmit, 2/3 port 1, 4/5 port 2, 6/7 UART receive/transmit, 8/9 timers 0/1, 10–13 external interrupts 0–3, 14/15 I2C receive/transmit. Codes 1, 2, 5 and 6 select sources 0, 1, 2 and 3. Codes 13 to 20 select source (code − 5).
- R4: Codes 9 and 10 select sources 4 and 5 only while `mux_mode` is 1. Codes 11 and 12 select sources 6 and 7 only while `mux_mode` is 0. In the other mux state these codes behave as reserved.
- R5: Reserved codes (3, 4, 7, 8 and 21–31) never make a channel ready, whatever happens on `ev_in`.
- R6: A rising edge on the selected source sets the channel's pending flag at that clock edge. An edge is a high sample after a low sample, and the sample before reset release counts as low. A synchronized enabled channel is ready while its flag is set. An accepted grant (`gnt_valid` and `gnt_ready` high together) clears the flag, unless a new edge arrives in the same cycle.
- R7: When any high-priority channel is ready, `gnt_ch` names a high-priority channel.
- R8: Within the winning group, the grant goes to the first ready channel after the last accepted channel of that group, in cyclic index order. Before any grant in a group, the search starts at channel 0.
- R9: An edge that reaches a channel whose flag is already set, and that is not granted in that cycle, raises `sync_drop` for that channel for one cycle after the edge.
- R10: `ch_irq[c]` is high for exactly the cycle after each cycle in which `blk_done[c]` is high.
- R11: When a channel's enable bit is cleared, its pending flag is lost. After the channel is enabled again, it is not ready until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_addr | input | 3 | Channel index for write and read |
| reg_wdata | input | 16 | Control word to write |
| reg_rdata | output | 16 | Control word of the addressed channel |
| mux_mode | input | 1 | Selects serial port 2 (1) or UART (0) for codes 9–12 |
| ev_in | input | 16 | Synchronization event sources |
| gnt_valid | output | 1 | A channel is ready and granted |
| gnt_ch | output | 3 | Index of the granted channel |
| gnt_ready | input | 1 | The transfer engine accepts the grant |
| blk_done | input | 6 | Per-channel block completion from the engine |
| ch_irq | output | 6 | Per-channel interrupt pulse |
| sync_drop | output | 6 | Per-channel lost-event pulse |

## Verification
The hardest behaviour to reach from the ports is the rotation order inside a group. It depends on which channel was last accepted in that group, and that history is not visible at the ports. The directed stimulus first builds a known history with single accepted grants. It then holds `gnt_ready` high over three ready low-priority channels and checks the exact order of the wrap. Lost-event pulses need a second edge on a flag that was never granted, so the bench pulses one timer source twice while withholding `gnt_ready`. A long random phase then mixes writes, edges, mux flips and grant acceptances against a behavioural model that is compared on every clock.

// File: rtl/dma_evsched_pkg.sv
package dma_evsched_pkg;

   localparam int unsigned EVT_NUM  = 16;
   localparam int unsigned EVT_W    = 4;
   localparam int unsigned EN_BIT   = 7;
   localparam int unsigned PRIO_BIT = 6;

   typedef struct packed {
      logic             vld;
      logic [EVT_W-1:0] src;
   } evt_route_t;

   // Maps a channel event code to a source index on ev_in.
   function automatic evt_route_t route_code(input logic [4:0] code, input logic mux);
      evt_route_t r;
      r.vld = 1'b0;
      r.src = '0;
      case (code)
         5'd1, 5'd2: begin
            r.vld = 1'b1;
            r.src = EVT_W'(code - 5'd1);
         end
         5'd5, 5'd6: begin
            r.vld = 1'b1;
            r.src = EVT_W'(code - 5'd3);
         end
         5'd9, 5'd10: begin
            r.vld = mux;
            r.src = EVT_W'(code - 5'd5);
         end
         5'd11, 5'd12: begin
            r.vld = ~mux;
            r.src = EVT_W'(code - 5'd5);
         end
         default: begin
            if (code >= 5'd13 && code <= 5'd20) begin
               r.vld = 1'b1;
               r.src = EVT_W'(code - 5'd5);
            end
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dma_evsel.sv
module dma_evsel
   import dma_evsched_pkg::*;
#(
   parameter int unsigned CODE_W = 5
) (
   input  logic [CODE_W-1:0]  code,
   input  logic               mux_mode,
   input  logic [EVT_NUM-1:0] ev_rise,
   output logic               trig,
   output logic               code_ok
);

   initial assert (CODE_W == 5) else $error("dma_evsel: CODE_W must be 5");

   evt_route_t rt;

   always_comb begin
      rt      = route_code(5'(code), mux_mode);
      code_ok = rt.vld;
      trig    = rt.vld & ev_rise[rt.src];
   end

endmodule

// File: rtl/dma_ch_ctx.sv
module dma_ch_ctx
   import dma_evsched_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              trig,
   input  logic              code_ok,
   input  logic              gnt,
   input  logic              done,
   output logic [DATA_W-1:0] ctl,
   output logic              ready,
   output logic              prio,
   output logic              drop,
   output logic              irq
);

   initial assert (DATA_W > EN_BIT && CODE_W < PRIO_BIT)
      else $error("dma_ch_ctx: field layout does not fit DATA_W");

   logic pend;
   logic en;
   logic unsync;

   assign en     = ctl[EN_BIT];
   assign prio   = ctl[PRIO_BIT];
   assign unsync = (ctl[CODE_W-1:0] == '0);
   assign ready  = en & (unsync | (pend & code_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         pend <= 1'b0;
         drop <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (wr_en) ctl <= wdata;
         pend <= en & ((pend & ~gnt) | trig);
         drop <= en & pend & ~gnt & trig;
         irq  <= done;
      end
   end

   p_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pend);
   p_gnt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && !trig) |=> !pend);
   p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> $past(pend));
   p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(done));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int unsigned N = 6,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  ready,
   input  logic [N-1:0]  prio,
   input  logic          accept,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);

   initial assert (N >= 2) else $error("dma_prio_arb: N must be at least 2");

   logic [IW-1:0] ptr_hi, ptr_lo, base;
   logic [N-1:0]  hi, lo, mask;
   logic          use_hi, found;
   int            j;

   always_comb begin
      hi     = ready & prio;
      lo     = ready & ~prio;
      use_hi = |hi;
      mask   = use_hi ? hi : lo;
      base   = use_hi ? ptr_hi : ptr_lo;
      found  = 1'b0;
      gnt_idx = '0;
      j = 0;
      for (int k = 1; k <= int'(N); k++) begin
         j = (int'(base) + k) % int'(N);
         if (!found && mask[j]) begin
            found   = 1'b1;
            gnt_idx = IW'(j);
         end
      end
      gnt_valid = found;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_hi <= IW'(N - 1);
         ptr_lo <= IW'(N - 1);
      end else if (gnt_valid && accept) begin
         if (use_hi) ptr_hi <= gnt_idx;
         else        ptr_lo <= gnt_idx;
      end
   end

   p_gnt_is_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> ready[gnt_idx]);
   p_hi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && (|(ready & prio))) |-> prio[gnt_idx]);
   p_work_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ready) |-> gnt_valid);

endmodule

// File: rtl/dma_evsched.sv
module dma_evsched
   import dma_evsched_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CODE_W = 5,
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CH_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              mux_mode,
   input  logic [EVT_NUM-1:0] ev_in,
   output logic              gnt_valid,
   output logic [CH_W-1:0]   gnt_ch,
   input  logic              gnt_ready,
   input  logic [NUM_CH-1:0] blk_done,
   output logic [NUM_CH-1:0] ch_irq,
   output logic [NUM_CH-1:0] sync_drop
);

   initial assert (NUM_CH >= 2 && CODE_W == 5)
      else $error("dma_evsched: unsupported parameter set");

   logic [EVT_NUM-1:0] ev_q;
   logic [EVT_NUM-1:0] ev_rise;
   logic [DATA_W-1:0]  ctl_a [NUM_CH];
   logic [NUM_CH-1:0]  rdy_v, prio_v;
   logic               accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= ev_in;
   end

   assign ev_rise = ev_in & ~ev_q;
   assign accept  = gnt_valid & gnt_ready;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic trig, code_ok;

      dma_evsel #(.CODE_W(CODE_W)) u_sel (
         .code     (ctl_a[c][CODE_W-1:0]),
         .mux_mode (mux_mode),
         .ev_rise  (ev_rise),
         .trig     (trig),
         .code_ok  (code_ok)
      );

      dma_ch_ctx #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ctx (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr && (reg_addr == CH_W'(c))),
         .wdata   (reg_wdata),
         .trig    (trig),
         .code_ok (code_ok),
         .gnt     (accept && (gnt_ch == CH_W'(c))),
         .done    (blk_done[c]),
         .ctl     (ctl_a[c]),
         .ready   (rdy_v[c]),
         .prio    (prio_v[c]),
         .drop    (sync_drop[c]),
         .irq     (ch_irq[c])
      );
   end

   dma_prio_arb #(.N(NUM_CH)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (rdy_v),
      .prio      (prio_v),
      .accept    (gnt_ready),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_ch)
   );

   logic [CODE_W-1:0] gnt_code;

   always_comb begin
      reg_rdata = '0;
      gnt_code  = '0;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         if (reg_addr == CH_W'(c)) reg_rdata = ctl_a[c];
         if (gnt_ch == CH_W'(c))   gnt_code  = ctl_a[c][CODE_W-1:0];
      end
   end

   p_rsv_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt_code == '0 || route_code(5'(gnt_code), mux_mode).vld));

endmodule

// File: tb/tb_dma_evsched.sv
module tb_dma_evsched;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mux_mode = 1'b0;
   logic [15:0] ev_in = '0;
   logic        gnt_valid;
   logic [2:0]  gnt_ch;
   logic        gnt_ready = 1'b0;
   logic [5:0]  blk_done = '0;
   logic [5:0]  ch_irq;
   logic [5:0]  sync_drop;

   always #10 clk = ~clk;

   dma_evsched dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mux_mode(mux_mode),
      .ev_in(ev_in), .gnt_valid(gnt_valid), .gnt_ch(gnt_ch),
      .gnt_ready(gnt_ready), .blk_done(blk_done), .ch_irq(ch_irq),
      .sync_drop(sync_drop)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   bit [15:0] m_ctl [6];
   bit        m_pend [6];
   bit [5:0]  m_drop, m_irq;
   int        last_hi = 5, last_lo = 5;
   bit [15:0] m_evq;

   function automatic int src_of(input int code, input bit mux);
      case (code)
         1: return 0;  2: return 1;  5: return 2;  6: return 3;
         9: return mux ? 4 : -1;    10: return mux ? 5 : -1;
         11: return mux ? -1 : 6;   12: return mux ? -1 : 7;
         13: return 8;  14: return 9;  15: return 10; 16: return 11;
         17: return 12; 18: return 13; 19: return 14; 20: return 15;
         default: return -1;
      endcase
   endfunction

   function automatic bit m_ready(input int c);
      int code;
      code = int'(m_ctl[c][4:0]);
      if (!m_ctl[c][7]) return 1'b0;
      if (code == 0) return 1'b1;
      return m_pend[c] && (src_of(code, mux_mode) >= 0);
   endfunction

   function automatic void m_pick(output bit v, output int ch);
      bit any_hi;
      int last;
      any_hi = 1'b0;
      for (int c = 0; c < 6; c++) if (m_ready(c) && m_ctl[c][6]) any_hi = 1'b1;
      last = any_hi ? last_hi : last_lo;
      v = 1'b0; ch = 0;
      for (int k = 1; k <= 6; k++) begin
         int idx;
         idx = (last + k) % 6;
         if (!v && m_ready(idx) && (m_ctl[idx][6] == any_hi)) begin
            v = 1'b1; ch = idx;
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 6; c++) begin m_ctl[c] = '0; m_pend[c] = 1'b0; end
         m_drop = '0; m_irq = '0; last_hi = 5; last_lo = 5; m_evq = '0;
      end else begin
         bit v, acc;
         int ch;
         bit [15:0] rise;
         bit [5:0] nd;
         bit np [6];
         m_pick(v, ch);
         acc  = v && gnt_ready;
         rise = ev_in & ~m_evq;
         for (int c = 0; c < 6; c++) begin
            int s;
            bit en, trig, g;
            en   = m_ctl[c][7];
            s    = src_of(int'(m_ctl[c][4:0]), mux_mode);
            trig = (s >= 0) && rise[s];
            g    = acc && (ch == c);
            np[c] = en && ((m_pend[c] && !g) || trig);
            nd[c] = en && m_pend[c] && !g && trig;
         end
         for (int c = 0; c < 6; c++) m_pend[c] = np[c];
         m_drop = nd;
         m_irq  = blk_done;
         if (acc) begin
            if (m_ctl[ch][6]) last_hi = ch; else last_lo = ch;
         end
         if (reg_wr && reg_addr < 3'd6) m_ctl[reg_addr] = reg_wdata;
         m_evq = ev_in;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit v;
         int ch;
         m_pick(v, ch);
         check("R2/R6 gnt_valid", int'(gnt_valid), int'(v));
         if (v) check("R8 gnt_ch", int'(gnt_ch), ch);
         check("R10 ch_irq", int'(ch_irq), int'(m_irq));
         check("R9 sync_drop", int'(sync_drop), int'(m_drop));
         check("R1 reg_rdata", int'(reg_rdata),
               (reg_addr < 3'd6) ? int'(m_ctl[reg_addr]) : 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic wr(input int ch, input int val);
      step();
      reg_wr = 1'b1; reg_addr = 3'(ch); reg_wdata = 16'(val);
      step();
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input int src);
      step(); ev_in[src] = 1'b1;
      step(); ev_in[src] = 1'b0;
   endtask

   task automatic grant_once();
      step(); gnt_ready = 1'b1;
      step(); gnt_ready = 1'b0;
   endtask

   task automatic dchk(input string tag, input int act, input int exp);
      #1;
      check(tag, act, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      dchk("R1 reset gnt_valid", int'(gnt_valid), 0);
      dchk("R1 reset rdata", int'(reg_rdata), 0);

      // R1 / R2: code 0 channel always ready
      wr(2, 16'h0080);
      reg_addr = 3'd2;
      dchk("R1 readback", int'(reg_rdata), 16'h0080);
      dchk("R2 unsync ready", int'(gnt_valid), 1);
      dchk("R2 unsync ch", int'(gnt_ch), 2);
      wr(7, 16'hFFFF);
      reg_addr = 3'd7;
      dchk("R1 out of range read", int'(reg_rdata), 0);
      wr(2, 16'h0000);
      dchk("R2 disabled idle", int'(gnt_valid), 0);

      // R3 / R6: serial port 0 receive on channel 1
      wr(1, 16'h0081);
      dchk("R6 no edge no request", int'(gnt_valid), 0);
      pulse(0);
      dchk("R3 code1 request", int'(gnt_valid), 1);
      dchk("R3 code1 channel", int'(gnt_ch), 1);
      grant_once();
      dchk("R6 grant clears", int'(gnt_valid), 0);

      // R4: mux-dependent codes
      wr(1, 16'h0089);
      mux_mode = 1'b0;
      pulse(4);
      dchk("R4 code9 mux0 reserved", int'(gnt_valid), 0);
      mux_mode = 1'b1;
      pulse(4);
      dchk("R4 code9 mux1 request", int'(gnt_valid), 1);
      grant_once();
      wr(1, 16'h008B);
      pulse(6);
      dchk("R4 code11 mux1 reserved", int'(gnt_valid), 0);
      mux_mode = 1'b0;
      pulse(6);
      dchk("R4 code11 mux0 request", int'(gnt_valid), 1);
      grant_once();

      // R5: reserved codes
      wr(1, 16'h0083);
      step(); ev_in = 16'hFFFF;
      step(); ev_in = 16'h0000;
      dchk("R5 code3 silent", int'(gnt_valid), 0);
      wr(1, 16'h0095);
      step(); ev_in = 16'hFFFF;
      step(); ev_in = 16'h0000;
      dchk("R5 code21 silent", int'(gnt_valid), 0);

      // R7: high group wins
      wr(0, 16'h0080);
      wr(3, 16'h00C0);
      dchk("R7 high wins", int'(gnt_ch), 3);

      // R8: rotation inside low group, last low grant was channel 1
      wr(3, 16'h0000);
      wr(1, 16'h0080);
      wr(4, 16'h0080);
      step(); gnt_ready = 1'b1;
      dchk("R8 rr first", int'(gnt_ch), 4);
      step(); dchk("R8 rr second", int'(gnt_ch), 0);
      step(); dchk("R8 rr third", int'(gnt_ch), 1);
      step(); dchk("R8 rr wrap", int'(gnt_ch), 4);
      gnt_ready = 1'b0;

      // R9: lost event on timer 0
      wr(0, 0); wr(1, 0); wr(4, 0);
      wr(5, 16'h008D);
      pulse(8);
      dchk("R9 first edge no drop", int'(sync_drop), 0);
      pulse(8);
      dchk("R9 second edge drops", int'(sync_drop), 6'b100000);
      step();
      dchk("R9 drop one cycle", int'(sync_drop), 0);

      // R11: disabling loses the pending flag
      wr(5, 16'h000D);
      wr(5, 16'h008D);
      dchk("R11 pending lost", int'(gnt_valid), 0);

      // R10: interrupt pulse
      step(); blk_done = 6'b000100;
      step(); blk_done = '0;
      dchk("R10 irq raised", int'(ch_irq), 6'b000100);
      step();
      dchk("R10 irq one cycle", int'(ch_irq), 0);

      // random phase, compared against the model each clock
      for (int i = 0; i < 6000; i++) begin
         int codes [10] = '{0, 1, 2, 3, 5, 9, 11, 13, 20, 25};
         step();
         reg_wr    = ($urandom % 6) == 0;
         reg_addr  = 3'($urandom % 8);
         reg_wdata = 16'(($urandom & 16'hFF20) | codes[$urandom % 10]
                     | ((($urandom % 4) != 0) ? 16'h0080 : 16'h0000)
                     | ((($urandom % 2) != 0) ? 16'h0040 : 16'h0000));
         ev_in     = 16'($urandom & $urandom);
         gnt_ready = ($urandom % 3) != 0;
         blk_done  = 6'($urandom & $urandom & $urandom);
         if (($urandom % 50) == 0) mux_mode = ~mux_mode;
      end
      step();
      reg_wr = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule